// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM command bus and owns that bus from reset until the memory is usable. After reset it holds the bus at NOP for a stabilization window whose length is computed from a clock-frequency parameter and a duration in microseconds. It then issues a precharge to every bank, two auto-refresh commands and a mode-register load, spacing each command by its own cycle-count parameter and driving NOP on every cycle in between.

The mode word comes either from an input port or from a parameter, chosen at elaboration. Its two reserved upper bits are always forced to zero on the address bus. Once the last wait has elapsed, a ready flag rises and stays high, with the bus parked at NOP, until the next reset. A reset at any point returns the bus to NOP at once and restarts the whole sequence.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted the bus shows NOP, with cs_n=0, ras_n=1, cas_n=1 and we_n=1. In the same state addr and ba are zero and ready is low.
- R2: The first command other than NOP appears on the STABLE_CYC-th rising edge after reset is released, where STABLE_CYC = CLK_MHZ*STABLE_US. Every earlier cycle is NOP.
- R3: The first command is precharge-all, encoded as cs_n=0, ras_n=0, cas_n=1 and we_n=0. It drives addr bit 10 high, every other addr bit low and ba=0.
- R4: Exactly two auto-refresh commands follow, encoded as cs_n=0, ras_n=0, cas_n=0 and we_n=1, with addr and ba at zero. The first comes T_RP cycles after the precharge and the second T_RC cycles after the first.
- R5: The mode load, with all four command pins low, comes T_RC cycles after the second refresh. During it, addr[9:0] carries mode bits 9..0, where bits 2:0 are burst length, bit 3 is burst type, bits 6:4 are CAS latency, bits 8:7 are operating mode and bit 9 is write-burst mode. addr[11:10] and ba are zero.
- R6: Every cycle between two commands, and between the mode load and ready, is NOP with addr=0.
- R7: ready rises T_MRD cycles after the mode load. From then until reset it stays high and the bus stays at NOP, so that exactly four non-NOP commands are issued per sequence.
- R8: mode_word has no effect on any output except in the mode-load cycle.
- R9: Asserting reset at any point returns the bus to NOP with ready low in the same cycle. The sequence then restarts from the beginning.
- R10: With USE_MODE_PORT=0 the mode load carries MODE_DEFAULT, with bits 11:10 forced to zero, and ignores mode_word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_word | input | 12 | Mode word for the mode-register load |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | BANK_W | Bank address |
| ready | output | 1 | Initialization complete, sticky until reset |

## Verification
Two things can land in the same cycle here.

The first is a reset arriving on the very cycle a command is on the bus. The bench asserts reset right after sampling the first stabilization slot, the last stabilization slot, the precharge, the cycle after it, the first refresh, the mode load and a cycle after ready. In the same moment it requires NOP with ready low, then requires a complete, correctly timed sequence on the next run.

The second is a change of the mode word coinciding with the mode-load slot. The bench drives a different junk word on every other cycle and the wanted word only for that slot. It judges that the wanted word appears exactly there, with bits 11:10 cleared, and that the junk never reaches the bus.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   localparam int MODE_W      = 12;
   localparam int PRE_ALL_BIT = 10;

   typedef enum logic [3:0] {
      ST_STABLE,
      ST_PRE,
      ST_WAIT_RP,
      ST_REF_A,
      ST_WAIT_RC_A,
      ST_REF_B,
      ST_WAIT_RC_B,
      ST_MODE,
      ST_WAIT_MRD,
      ST_READY
   } seq_state_t;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } cmd_pins_t;

   localparam cmd_pins_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
   localparam cmd_pins_t CMD_PRE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
   localparam cmd_pins_t CMD_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
   localparam cmd_pins_t CMD_MODE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
   parameter int            W       = 8,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= RST_VAL;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/sdram_init_modefmt.sv
module sdram_init_modefmt
   import sdram_init_pkg::*;
#(
   parameter int                ADDR_W        = 12,
   parameter bit                USE_MODE_PORT = 1'b1,
   parameter logic [MODE_W-1:0] MODE_DEFAULT  = 12'h032
) (
   input  logic [MODE_W-1:0] mode_word,
   output logic [ADDR_W-1:0] mode_addr
);

   localparam int PAD_W = ADDR_W - MODE_W;

   logic [MODE_W-1:0] src;

   generate
      if (USE_MODE_PORT) begin : g_port_src
         assign src = mode_word;
      end else begin : g_param_src
         logic unused_mode;
         assign unused_mode = ^mode_word;
         assign src = MODE_DEFAULT;
      end

      if (PAD_W > 0) begin : g_pad
         assign mode_addr = {{PAD_W{1'b0}}, 2'b00, src[MODE_W-3:0]};
      end else begin : g_nopad
         assign mode_addr = {2'b00, src[MODE_W-3:0]};
      end
   endgenerate

endmodule

// File: rtl/sdram_init_cmdenc.sv
module sdram_init_cmdenc
   import sdram_init_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int BANK_W = 2
) (
   input  seq_state_t        state,
   input  logic [ADDR_W-1:0] mode_addr,
   output cmd_pins_t         cmd,
   output logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] ba
);

   always_comb begin
      cmd  = CMD_NOP;
      addr = '0;
      ba   = '0;
      unique case (state)
         ST_PRE: begin
            cmd               = CMD_PRE;
            addr[PRE_ALL_BIT] = 1'b1;
         end
         ST_REF_A, ST_REF_B: begin
            cmd = CMD_REF;
         end
         ST_MODE: begin
            cmd  = CMD_MODE;
            addr = mode_addr;
         end
         default: begin
            cmd = CMD_NOP;
         end
      endcase
   end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
   import sdram_init_pkg::*;
#(
   parameter int                CLK_MHZ       = 50,
   parameter int                STABLE_US     = 100,
   parameter int                T_RP          = 3,
   parameter int                T_RC          = 7,
   parameter int                T_MRD         = 2,
   parameter int                ADDR_W        = 12,
   parameter int                BANK_W        = 2,
   parameter bit                USE_MODE_PORT = 1'b1,
   parameter logic [MODE_W-1:0] MODE_DEFAULT  = 12'h032
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [MODE_W-1:0]   mode_word,
   output logic                cs_n,
   output logic                ras_n,
   output logic                cas_n,
   output logic                we_n,
   output logic [ADDR_W-1:0]   addr,
   output logic [BANK_W-1:0]   ba,
   output logic                ready
);

   localparam int STABLE_CYC = CLK_MHZ * STABLE_US;
   localparam int MAX_A      = (STABLE_CYC > T_RP)  ? STABLE_CYC : T_RP;
   localparam int MAX_B      = (T_RC > T_MRD)       ? T_RC       : T_MRD;
   localparam int CNT_MAX    = (MAX_A > MAX_B)      ? MAX_A      : MAX_B;
   localparam int CNT_W      = $clog2(CNT_MAX + 1);

   generate
      if (T_RP < 2 || T_RC < 2 || T_MRD < 2) begin : g_bad_wait
         $error("command spacing parameters must be at least 2");
      end
      if (STABLE_CYC < 2) begin : g_bad_stable
         $error("stabilization window must be at least 2 cycles");
      end
      if (ADDR_W < MODE_W) begin : g_bad_addr
         $error("address bus narrower than mode word");
      end
      if (BANK_W < 1) begin : g_bad_bank
         $error("bank address needs at least one bit");
      end
   endgenerate

   seq_state_t        state, nxt;
   logic              tmr_load, tmr_zero;
   logic [CNT_W-1:0]  tmr_val;
   logic [ADDR_W-1:0] mode_addr;
   cmd_pins_t         cmd;

   sdram_init_timer #(
      .W       (CNT_W),
      .RST_VAL (CNT_W'(STABLE_CYC - 1))
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   sdram_init_modefmt #(
      .ADDR_W        (ADDR_W),
      .USE_MODE_PORT (USE_MODE_PORT),
      .MODE_DEFAULT  (MODE_DEFAULT)
   ) u_modefmt (
      .mode_word (mode_word),
      .mode_addr (mode_addr)
   );

   sdram_init_cmdenc #(
      .ADDR_W (ADDR_W),
      .BANK_W (BANK_W)
   ) u_cmdenc (
      .state     (state),
      .mode_addr (mode_addr),
      .cmd       (cmd),
      .addr      (addr),
      .ba        (ba)
   );

   always_comb begin
      nxt      = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state)
         ST_STABLE:    if (tmr_zero) nxt = ST_PRE;
         ST_PRE: begin
            nxt      = ST_WAIT_RP;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_RP - 2);
         end
         ST_WAIT_RP:   if (tmr_zero) nxt = ST_REF_A;
         ST_REF_A: begin
            nxt      = ST_WAIT_RC_A;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_RC - 2);
         end
         ST_WAIT_RC_A: if (tmr_zero) nxt = ST_REF_B;
         ST_REF_B: begin
            nxt      = ST_WAIT_RC_B;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_RC - 2);
         end
         ST_WAIT_RC_B: if (tmr_zero) nxt = ST_MODE;
         ST_MODE: begin
            nxt      = ST_WAIT_MRD;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_MRD - 2);
         end
         ST_WAIT_MRD:  if (tmr_zero) nxt = ST_READY;
         ST_READY:     nxt = ST_READY;
         default:      nxt = ST_STABLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_STABLE;
      else        state <= nxt;
   end

   assign cs_n  = cmd.cs_n;
   assign ras_n = cmd.ras_n;
   assign cas_n = cmd.cas_n;
   assign we_n  = cmd.we_n;
   assign ready = (state == ST_READY);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |-> (cmd == CMD_NOP && !ready && addr == '0));

   assert_stable_nop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STABLE) |-> (cmd == CMD_NOP));

   assert_pre_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_PRE) |-> (addr[PRE_ALL_BIT] && ba == '0));

   assert_ref_quiet_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_REF) |-> (addr == '0 && !ready));

   assert_mode_after_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_MODE) |-> ($past(state) == ST_WAIT_RC_B));

   assert_mode_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_MODE) |-> (addr[MODE_W-1:MODE_W-2] == 2'b00 && ba == '0));

   assert_single_cycle_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

   assert_ready_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (cmd == CMD_NOP && addr == '0));

endmodule

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;

   localparam int CLK_MHZ = 50;
   localparam int STAB_US = 1;
   localparam int TRP     = 3;
   localparam int TRC     = 5;
   localparam int TMRD    = 2;
   localparam logic [11:0] PAR_MODE = 12'hE37;

   localparam int S_PRE  = CLK_MHZ * STAB_US;
   localparam int S_REFA = S_PRE + TRP;
   localparam int S_REFB = S_REFA + TRC;
   localparam int S_MODE = S_REFB + TRC;
   localparam int S_RDY  = S_MODE + TMRD;

   localparam logic [18:0] V_NOP = {4'b0111, 1'b0, 2'b00, 12'h000};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] mode_word = 12'h000;

   always #10 clk = ~clk;

   logic        cs_n, ras_n, cas_n, we_n, ready;
   logic [11:0] addr;
   logic [1:0]  ba;
   logic        p_cs_n, p_ras_n, p_cas_n, p_we_n, p_ready;
   logic [11:0] p_addr;
   logic [1:0]  p_ba;

   sdram_init_seq #(
      .CLK_MHZ (CLK_MHZ), .STABLE_US (STAB_US),
      .T_RP (TRP), .T_RC (TRC), .T_MRD (TMRD)
   ) uut (
      .clk (clk), .rst_n (rst_n), .mode_word (mode_word),
      .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
      .addr (addr), .ba (ba), .ready (ready)
   );

   sdram_init_seq #(
      .CLK_MHZ (CLK_MHZ), .STABLE_US (STAB_US),
      .T_RP (TRP), .T_RC (TRC), .T_MRD (TMRD),
      .USE_MODE_PORT (1'b0), .MODE_DEFAULT (PAR_MODE)
   ) uut_par (
      .clk (clk), .rst_n (rst_n), .mode_word (mode_word),
      .cs_n (p_cs_n), .ras_n (p_ras_n), .cas_n (p_cas_n), .we_n (p_we_n),
      .addr (p_addr), .ba (p_ba), .ready (p_ready)
   );

   logic [18:0] obs, obs_par;
   assign obs     = {cs_n, ras_n, cas_n, we_n, ready, ba, addr};
   assign obs_par = {p_cs_n, p_ras_n, p_cas_n, p_we_n, p_ready, p_ba, p_addr};

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check_vec(input string tag, input logic [18:0] act, input logic [18:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run_seq(input logic [11:0] mw, input int stop);
      logic [18:0] exp;
      string       tag;
      @(negedge clk);
      rst_n     = 1'b0;
      mode_word = ~mw;
      repeat (2) begin
         @(negedge clk);
         check_vec("R1 reset state", obs, V_NOP);
      end
      rst_n = 1'b1;
      #1;
      for (int k = 0; k <= S_RDY + 4; k++) begin
         if (k > 0) @(negedge clk);
         if (k < S_PRE) begin
            tag = "R2 R8 stabilization NOP"; exp = V_NOP;
         end else if (k == S_PRE) begin
            tag = "R3 precharge-all"; exp = {4'b0010, 1'b0, 2'b00, 12'h400};
         end else if (k == S_REFA || k == S_REFB) begin
            tag = "R4 auto-refresh"; exp = {4'b0001, 1'b0, 2'b00, 12'h000};
         end else if (k == S_MODE) begin
            tag = "R5 mode load"; exp = {4'b0000, 1'b0, 2'b00, mw & 12'h3FF};
         end else if (k < S_RDY) begin
            tag = "R6 R8 gap NOP"; exp = V_NOP;
         end else begin
            tag = "R7 ready hold"; exp = {4'b0111, 1'b1, 2'b00, 12'h000};
         end
         check_vec(tag, obs, exp);
         if (k == S_MODE)
            check_vec("R10 parameter mode word", obs_par,
                      {4'b0000, 1'b0, 2'b00, PAR_MODE & 12'h3FF});
         mode_word = (k + 1 == S_MODE) ? mw : (12'(k * 173) ^ ~mw);
         if (k == stop) begin
            rst_n = 1'b0;
            #1;
            check_vec("R9 reset abort", obs, V_NOP);
            check_vec("R9 reset abort param", obs_par, V_NOP);
            return;
         end
      end
   endtask

   initial begin
      int stops [8];
      stops = '{0, S_PRE - 1, S_PRE, S_PRE + 1, S_REFA, S_MODE, S_RDY + 1, 1};
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      run_seq(12'h000, -1);
      run_seq(12'hFFF, -1);
      for (int i = 0; i < 10; i++) begin
         run_seq(12'(i * 12'h2E5 + 12'h0F3), -1);
      end
      for (int i = 0; i < 8; i++) begin
         run_seq(12'h5A5 ^ 12'(i), stops[i]);
      end
      run_seq(12'h3C6, -1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      wait (cyc >= 100000);
      n_cmp++;
      n_bad++;
      $display("FAIL R7 watchdog: actual %0d cycles expected below 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule